// File: doc/BRIEF.md
# Machine-Mode Control and Status Register File

This block keeps the machine-level control and status registers of a small 32-bit RISC-V hart. The execute stage presents a 12-bit register address, write data, a write strobe, a read strobe and the privilege level the hart is running at. The block returns the read data in the same cycle. It also raises an illegal-access flag, which the pipeline turns into an illegal-instruction exception. A write that is accepted is stored at the next rising clock edge.

Every write is made legal field by field before it is stored. Fixed fields always read their constant value. Writable fields store what was written. Fields with restricted encodings keep only legal values. A separate trap-entry port loads the exception PC, the cause and the trap value in one cycle. The three machine interrupt-pending bits are taken live from hardware inputs.

Top module: `mcsr_file`

## Requirements
- R1: An access, read or write, to an address that is not implemented raises the illegal flag, returns read data 0 and changes no register. The implemented addresses are 0x300, 0x301, 0x304, 0x305, 0x310, 0x340–0x344, 0x7C0 and 0xF11–0xF14.
- R2: Address bits 11:10 equal to 2'b11 mark a read-only register. A write to such a register raises the illegal flag. A read of 0xF11, 0xF12, 0xF13 or 0xF14 returns the VENDOR_ID, ARCH_ID, IMP_ID or HART_ID parameter respectively.
- R3: Address bits 9:8 give the lowest privilege allowed to access the register (0 user, 1 supervisor, 3 machine). An access from a lower privilege, for example the scratch register at 0x340 accessed from privilege 0 or 1, raises the illegal flag.
- R4: The ISA register 0x301 always reads 0x40141104, and writes to it leave it unchanged.
- R5: In the status register 0x300, bits 31, 16:15, 14:13, 10:9 and 6, and the reserved bits 30:23, 4, 2 and 0, always read 0.
- R6: In the status register, bits 22, 21, 20, 19, 18, 17, 12:11, 8, 7, 5, 3 and 1 read back the value last written.
- R7: The upper status register 0x310 always reads 0, including its endianness bits 4 and 5.
- R8: The trap vector register 0x305 stores a mode in bits 1:0. For a written mode of 0 it stores bits 31:2 with the mode 0. For a written mode of 1 it stores bits 31:8, clears bits 7:2 and sets the mode to 1. A written mode of 2 or 3 leaves the whole register unchanged.
- R9: In the interrupt-enable register 0x304, only bits 11, 9, 7, 5, 3 and 1 are writable. All other bits read 0.
- R10: In the interrupt-pending register 0x344, bit 11 follows the external-pending input, bit 7 the timer-pending input and bit 3 the software-pending input, whatever is written. Bits 9, 5 and 1 are writable, and all other bits read 0.
- R11: The cache-enable register 0x7C0 resets to 1. Only bit 0 is writable, and bits 31:1 read 0.
- R12: A trap-entry pulse loads 0x341 with the trap PC and 0x342 with {interrupt flag, 31-bit code}, where bit 31 is 1 for an interrupt. It also loads 0x343 with the trap value. The new values are readable after the next clock edge.
- R13: A trap-entry update wins over a software write to 0x341–0x343 in the same cycle, while a software write to any other register in that cycle still lands. A write flagged illegal is dropped.
- R14: After reset every writable field reads 0, except the cache-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | 32 | Write data |
| csr_we_i | input | 1 | Write strobe |
| csr_re_i | input | 1 | Read strobe |
| priv_i | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| trap_i | input | 1 | Trap-entry pulse |
| trap_pc_i | input | 32 | PC of the trapping instruction |
| trap_irq_i | input | 1 | Trap is an interrupt |
| trap_code_i | input | 31 | Exception or interrupt code |
| trap_val_i | input | 32 | Faulting address or zero |
| hw_meip_i | input | 1 | Machine external interrupt pending |
| hw_mtip_i | input | 1 | Machine timer interrupt pending |
| hw_msip_i | input | 1 | Machine software interrupt pending |
| csr_rdata_o | output | 32 | Read data, 0 when the access is illegal |
| csr_illegal_o | output | 1 | Illegal-access flag |

## Verification
The bench builds the block with VENDOR_ID=0x1234_5678, ARCH_ID=3, IMP_ID=0x0000_00A5 and HART_ID=0x0000_0002, so each read-only identity register returns a value that can be told apart from the others and from zero. With the address space only 4096 entries wide, the bench reads every address at every privilege level and writes all ones to every address. That reaches every decode hole, every privilege fault and every read-only fault. It then compares each legalized register against a shadow model over several data patterns, all four trap-vector modes, all eight hardware-pending combinations and trap entry racing software writes.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

  localparam logic [11:0] A_STATUS  = 12'h300;
  localparam logic [11:0] A_ISA     = 12'h301;
  localparam logic [11:0] A_IE      = 12'h304;
  localparam logic [11:0] A_TVEC    = 12'h305;
  localparam logic [11:0] A_STATUSH = 12'h310;
  localparam logic [11:0] A_SCRATCH = 12'h340;
  localparam logic [11:0] A_EPC     = 12'h341;
  localparam logic [11:0] A_CAUSE   = 12'h342;
  localparam logic [11:0] A_TVAL    = 12'h343;
  localparam logic [11:0] A_IP      = 12'h344;
  localparam logic [11:0] A_CACHE   = 12'h7C0;
  localparam logic [11:0] A_ID_BASE = 12'hF11;
  localparam int          ID_COUNT  = 4;

  localparam logic [31:0] ISA_WORD    = 32'h4014_1104;
  localparam logic [31:0] STATUS_MASK = 32'h007E_19AA;
  localparam logic [31:0] IE_MASK     = 32'h0000_0AAA;
  localparam logic [31:0] IP_SW_MASK  = 32'h0000_0222;

  typedef struct packed {
    logic                status;
    logic                isa;
    logic                ie;
    logic                tvec;
    logic                statush;
    logic                scratch;
    logic                epc;
    logic                cause;
    logic                tval;
    logic                ip;
    logic                cache;
    logic [ID_COUNT-1:0] id;
  } csr_sel_t;

  // Trap vector legalization: reserved modes keep the old value,
  // vectored mode forces 256-byte base alignment.
  function automatic logic [31:0] tvec_legal(input logic [31:0] old_v,
                                             input logic [31:0] wr_v);
    if (wr_v[1])      return old_v;
    else if (wr_v[0]) return {wr_v[31:8], 8'h01};
    else              return {wr_v[31:2], 2'b00};
  endfunction

  // Pending-bit image of the three hardware-driven machine sources.
  function automatic logic [31:0] ip_hw_bits(input logic ext, input logic tmr,
                                             input logic sw);
    return {20'b0, ext, 3'b0, tmr, 3'b0, sw, 3'b0};
  endfunction

endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
(
  input  logic [11:0] addr_i,
  input  logic [1:0]  priv_i,
  input  logic        we_i,
  input  logic        re_i,
  output csr_sel_t    sel_o,
  output logic        illegal_o
);

  logic [ID_COUNT-1:0] id_hit;
  logic access_w, unimpl_w, priv_fault_w, ro_fault_w;

  generate
    for (genvar g = 0; g < ID_COUNT; g++) begin : g_id
      assign id_hit[g] = (addr_i == A_ID_BASE + 12'(g));
    end
  endgenerate

  always_comb begin
    sel_o         = '0;
    sel_o.status  = (addr_i == A_STATUS);
    sel_o.isa     = (addr_i == A_ISA);
    sel_o.ie      = (addr_i == A_IE);
    sel_o.tvec    = (addr_i == A_TVEC);
    sel_o.statush = (addr_i == A_STATUSH);
    sel_o.scratch = (addr_i == A_SCRATCH);
    sel_o.epc     = (addr_i == A_EPC);
    sel_o.cause   = (addr_i == A_CAUSE);
    sel_o.tval    = (addr_i == A_TVAL);
    sel_o.ip      = (addr_i == A_IP);
    sel_o.cache   = (addr_i == A_CACHE);
    sel_o.id      = id_hit;
  end

  assign access_w     = we_i | re_i;
  assign unimpl_w     = (sel_o == '0);
  assign priv_fault_w = (priv_i < addr_i[9:8]);
  assign ro_fault_w   = we_i && (addr_i[11:10] == 2'b11);
  assign illegal_o    = access_w && (unimpl_w || priv_fault_w || ro_fault_w);

endmodule

// File: rtl/mcsr_regs.sv
module mcsr_regs
  import mcsr_pkg::*;
#(
  parameter logic CACHE_RST = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  csr_sel_t    sel_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        trap_i,
  input  logic [31:0] trap_pc_i,
  input  logic        trap_irq_i,
  input  logic [30:0] trap_code_i,
  input  logic [31:0] trap_val_i,
  output logic [31:0] status_q,
  output logic [31:0] ie_q,
  output logic [31:0] tvec_q,
  output logic [31:0] scratch_q,
  output logic [31:0] epc_q,
  output logic [31:0] cause_q,
  output logic [31:0] tval_q,
  output logic [31:0] ip_sw_q,
  output logic        cache_q
);

  logic tvec_wr_w;
  assign tvec_wr_w = wr_i && sel_i.tvec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q  <= '0;
      ie_q      <= '0;
      tvec_q    <= '0;
      scratch_q <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
      tval_q    <= '0;
      ip_sw_q   <= '0;
      cache_q   <= CACHE_RST;
    end else begin
      if (wr_i) begin
        if (sel_i.status)  status_q  <= wdata_i & STATUS_MASK;
        if (sel_i.ie)      ie_q      <= wdata_i & IE_MASK;
        if (tvec_wr_w)     tvec_q    <= tvec_legal(tvec_q, wdata_i);
        if (sel_i.scratch) scratch_q <= wdata_i;
        if (sel_i.epc)     epc_q     <= wdata_i;
        if (sel_i.cause)   cause_q   <= wdata_i;
        if (sel_i.tval)    tval_q    <= wdata_i;
        if (sel_i.ip)      ip_sw_q   <= wdata_i & IP_SW_MASK;
        if (sel_i.cache)   cache_q   <= wdata_i[0];
      end
      // trap entry is placed last so it overrides a same-cycle software write
      if (trap_i) begin
        epc_q   <= trap_pc_i;
        cause_q <= {trap_irq_i, trap_code_i};
        tval_q  <= trap_val_i;
      end
    end
  end

  AST_TVEC_RESERVED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvec_wr_w && wdata_i[1]) |=> $stable(tvec_q)); // R8

  AST_TVEC_VECTORED_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvec_wr_w && wdata_i[1:0] == 2'b01) |=> (tvec_q[7:0] == 8'h01)); // R8

  AST_TRAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (epc_q == $past(trap_pc_i) && cause_q[31] == $past(trap_irq_i)
                && tval_q == $past(trap_val_i))); // R12

endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
  import mcsr_pkg::*;
#(
  parameter logic [31:0] VENDOR_ID = 32'h0000_0000,
  parameter logic [31:0] ARCH_ID   = 32'h0000_0003,
  parameter logic [31:0] IMP_ID    = 32'h0000_0000,
  parameter logic [31:0] HART_ID   = 32'h0000_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [11:0] csr_addr_i,
  input  logic [31:0] csr_wdata_i,
  input  logic        csr_we_i,
  input  logic        csr_re_i,
  input  logic [1:0]  priv_i,
  input  logic        trap_i,
  input  logic [31:0] trap_pc_i,
  input  logic        trap_irq_i,
  input  logic [30:0] trap_code_i,
  input  logic [31:0] trap_val_i,
  input  logic        hw_meip_i,
  input  logic        hw_mtip_i,
  input  logic        hw_msip_i,
  output logic [31:0] csr_rdata_o,
  output logic        csr_illegal_o
);

  localparam logic [31:0] ID_VALUES [ID_COUNT] = '{VENDOR_ID, ARCH_ID, IMP_ID, HART_ID};

  csr_sel_t    sel_w;
  logic        wr_ok_w;
  logic [31:0] status_q, ie_q, tvec_q, scratch_q, epc_q, cause_q, tval_q, ip_sw_q;
  logic        cache_q;
  logic [31:0] rdata_w;
  logic [256:0] state_bus_w;

  mcsr_decode u_decode (
    .addr_i    (csr_addr_i),
    .priv_i    (priv_i),
    .we_i      (csr_we_i),
    .re_i      (csr_re_i),
    .sel_o     (sel_w),
    .illegal_o (csr_illegal_o)
  );

  assign wr_ok_w = csr_we_i && !csr_illegal_o;

  mcsr_regs #(.CACHE_RST(1'b1)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel_w),
    .wr_i        (wr_ok_w),
    .wdata_i     (csr_wdata_i),
    .trap_i      (trap_i),
    .trap_pc_i   (trap_pc_i),
    .trap_irq_i  (trap_irq_i),
    .trap_code_i (trap_code_i),
    .trap_val_i  (trap_val_i),
    .status_q    (status_q),
    .ie_q        (ie_q),
    .tvec_q      (tvec_q),
    .scratch_q   (scratch_q),
    .epc_q       (epc_q),
    .cause_q     (cause_q),
    .tval_q      (tval_q),
    .ip_sw_q     (ip_sw_q),
    .cache_q     (cache_q)
  );

  always_comb begin
    rdata_w = '0;
    if (sel_w.status)  rdata_w = status_q;
    if (sel_w.isa)     rdata_w = ISA_WORD;
    if (sel_w.ie)      rdata_w = ie_q;
    if (sel_w.tvec)    rdata_w = tvec_q;
    if (sel_w.scratch) rdata_w = scratch_q;
    if (sel_w.epc)     rdata_w = epc_q;
    if (sel_w.cause)   rdata_w = cause_q;
    if (sel_w.tval)    rdata_w = tval_q;
    if (sel_w.ip)      rdata_w = ip_sw_q | ip_hw_bits(hw_meip_i, hw_mtip_i, hw_msip_i);
    if (sel_w.cache)   rdata_w = {31'b0, cache_q};
    for (int k = 0; k < ID_COUNT; k++) begin
      if (sel_w.id[k]) rdata_w = ID_VALUES[k];
    end
  end

  assign csr_rdata_o = csr_illegal_o ? '0 : rdata_w;

  assign state_bus_w = {status_q, ie_q, tvec_q, scratch_q, epc_q, cause_q, tval_q,
                        ip_sw_q, cache_q};

  AST_ILLEGAL_NO_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_illegal_o && !trap_i) |=> $stable(state_bus_w)); // R1

  AST_RO_WRITE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_addr_i[11:10] == 2'b11) |-> csr_illegal_o); // R2

  AST_SCRATCH_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((csr_we_i || csr_re_i) && csr_addr_i == A_SCRATCH && priv_i != 2'b11)
      |-> csr_illegal_o); // R3

  AST_ISA_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == A_ISA && !csr_illegal_o) |-> (csr_rdata_o == ISA_WORD)); // R4

  AST_CACHE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == A_CACHE && !csr_illegal_o) |-> (csr_rdata_o[31:1] == '0)); // R11

endmodule

// File: tb/test_mcsr_file.sv
`timescale 1ns/1ps
module test_mcsr_file;

  localparam logic [31:0] P_VENDOR = 32'h1234_5678;
  localparam logic [31:0] P_ARCH   = 32'd3;
  localparam logic [31:0] P_IMP    = 32'h0000_00A5;
  localparam logic [31:0] P_HART   = 32'h0000_0002;

  logic clk = 0, rst_n = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0;
  logic we = 0, re = 0;
  logic [1:0] priv = 2'd3;
  logic trap = 0, t_irq = 0;
  logic [31:0] t_pc = 0, t_val = 0;
  logic [30:0] t_code = 0;
  logic meip = 0, mtip = 0, msip = 0;
  logic [31:0] rdata;
  logic illegal;

  int errors = 0, checks = 0;
  bit done = 0;

  // shadow model
  logic [31:0] s_status, s_ie, s_tvec, s_scratch, s_epc, s_cause, s_tval, s_ipsw;
  logic        s_cache;

  always #2 clk = ~clk;

  mcsr_file #(.VENDOR_ID(P_VENDOR), .ARCH_ID(P_ARCH), .IMP_ID(P_IMP), .HART_ID(P_HART))
  i_mcsr_file (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wdata_i(wdata),
    .csr_we_i(we), .csr_re_i(re), .priv_i(priv), .trap_i(trap), .trap_pc_i(t_pc),
    .trap_irq_i(t_irq), .trap_code_i(t_code), .trap_val_i(t_val),
    .hw_meip_i(meip), .hw_mtip_i(mtip), .hw_msip_i(msip),
    .csr_rdata_o(rdata), .csr_illegal_o(illegal)
  );

  function automatic logic [31:0] bits_mask(input int which);
    logic [31:0] m = 0;
    int st[13] = '{1, 3, 5, 7, 8, 11, 12, 17, 18, 19, 20, 21, 22};
    int ie[6]  = '{1, 3, 5, 7, 9, 11};
    int ip[3]  = '{1, 5, 9};
    if (which == 0) foreach (st[i]) m[st[i]] = 1'b1;
    if (which == 1) foreach (ie[i]) m[ie[i]] = 1'b1;
    if (which == 2) foreach (ip[i]) m[ip[i]] = 1'b1;
    return m;
  endfunction

  function automatic bit is_impl(input logic [11:0] a);
    case (a)
      12'h300, 12'h301, 12'h304, 12'h305, 12'h310, 12'h340, 12'h341, 12'h342,
      12'h343, 12'h344, 12'h7C0, 12'hF11, 12'hF12, 12'hF13, 12'hF14: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_ill(input logic [11:0] a, input bit w, input logic [1:0] p);
    if (!is_impl(a)) return 1;
    if (int'(p) < int'(a[9:8])) return 1;
    if (w && a[11] && a[10]) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    logic [31:0] hw;
    hw = 0; hw[11] = meip; hw[7] = mtip; hw[3] = msip;
    case (a)
      12'h300: return s_status;
      12'h301: return (32'd1 << 30) | 32'h0014_1104;
      12'h304: return s_ie;
      12'h305: return s_tvec;
      12'h340: return s_scratch;
      12'h341: return s_epc;
      12'h342: return s_cause;
      12'h343: return s_tval;
      12'h344: return s_ipsw | hw;
      12'h7C0: return {31'd0, s_cache};
      12'hF11: return P_VENDOR;
      12'hF12: return P_ARCH;
      12'hF13: return P_IMP;
      12'hF14: return P_HART;
      default: return 0;
    endcase
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    case (a)
      12'h300: s_status = d & bits_mask(0);
      12'h304: s_ie = d & bits_mask(1);
      12'h305: begin
        if (d[1:0] == 2'd0) s_tvec = d - (d % 4);
        else if (d[1:0] == 2'd1) s_tvec = (d - (d % 256)) + 1;
      end
      12'h340: s_scratch = d;
      12'h341: s_epc = d;
      12'h342: s_cause = d;
      12'h343: s_tval = d;
      12'h344: s_ipsw = d & bits_mask(2);
      12'h7C0: s_cache = d[0];
      default: ;
    endcase
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [11:0] a, input logic [31:0] d, input bit w, input bit r,
                     input logic [1:0] p, output logic [31:0] rd, output logic il);
    @(negedge clk);
    addr = a; wdata = d; we = w; re = r; priv = p;
    #1;
    rd = rdata; il = illegal;
    @(posedge clk);
    #0.5;
    we = 0; re = 0; trap = 0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input string req);
    logic [31:0] rd; logic il; logic [31:0] e;
    acc(a, 0, 0, 1, 2'd3, rd, il);
    e = exp_read(a);
    chk(il == 1'b0 && rd == e, req, rd, e);
  endtask

  task automatic wr_do(input logic [11:0] a, input logic [31:0] d, input logic [1:0] p,
                       input string req);
    logic [31:0] rd; logic il; bit ei;
    ei = exp_ill(a, 1, p);
    acc(a, d, 1, 0, p, rd, il);
    chk(il == ei, req, {31'd0, il}, {31'd0, ei});
    if (!ei) model_write(a, d);
  endtask

  task automatic read_all(input string req);
    logic [11:0] list[15] = '{12'h300, 12'h301, 12'h304, 12'h305, 12'h310, 12'h340,
                              12'h341, 12'h342, 12'h343, 12'h344, 12'h7C0, 12'hF11,
                              12'hF12, 12'hF13, 12'hF14};
    foreach (list[i]) rd_chk(list[i], req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic il;
    logic [31:0] pats[5] = '{32'h0, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'hFFFF_FFFF, 32'h1234_5679};
    logic [11:0] wr_list[9] = '{12'h300, 12'h301, 12'h304, 12'h310, 12'h340, 12'h341,
                                12'h342, 12'h343, 12'h344};
    s_status = 0; s_ie = 0; s_tvec = 0; s_scratch = 0; s_epc = 0; s_cause = 0;
    s_tval = 0; s_ipsw = 0; s_cache = 1;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;

    // R14 R1 R2 R4 R7 R11: reset values and full address sweep at machine level
    for (int a = 0; a < 4096; a++) begin
      acc(12'(a), 0, 0, 1, 2'd3, rd, il);
      chk(il == exp_ill(12'(a), 0, 2'd3) && rd == (il ? 32'd0 : exp_read(12'(a))),
          "R14 R1 reset read sweep", rd, exp_read(12'(a)));
    end

    // R3: lower privilege sweeps
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 4096; a++) begin
        acc(12'(a), 0, 0, 1, 2'(p), rd, il);
        chk(il == exp_ill(12'(a), 0, 2'(p)) && (!il || rd == 0),
            "R3 privilege sweep", {31'd0, il}, {31'd0, exp_ill(12'(a), 0, 2'(p))});
      end
    end

    // R1 R2 R13: write all ones to every address, then compare all registers
    meip = 1; mtip = 0; msip = 1;
    for (int a = 0; a < 4096; a++) wr_do(12'(a), 32'hFFFF_FFFF, 2'd3, "R1 R2 write sweep");
    read_all("R5 R6 R9 R10 R11 R13 after write sweep");

    // R5 R6 R7 R9 R10 R11 R4: pattern writes
    foreach (pats[i]) begin
      foreach (wr_list[j]) wr_do(wr_list[j], pats[i], 2'd3, "R6 pattern write");
      wr_do(12'h7C0, pats[i], 2'd3, "R11 pattern write");
      read_all("R4 R5 R6 R7 R9 R10 R11 pattern readback");
    end

    // R8: trap vector modes
    foreach (pats[i]) begin
      for (int m = 0; m < 4; m++) begin
        wr_do(12'h305, {pats[i][31:2], 2'(m)} ^ 32'h0000_0F00, 2'd3, "R8 tvec write");
        rd_chk(12'h305, "R8 tvec readback");
      end
    end

    // R10: hardware pending inputs
    for (int h = 0; h < 8; h++) begin
      {meip, mtip, msip} = 3'(h);
      wr_do(12'h344, 32'hFFFF_FFFF ^ (32'(h) << 9), 2'd3, "R10 ip write");
      rd_chk(12'h344, "R10 hw pending follows inputs");
    end

    // R3 R13: scratch write from supervisor is dropped
    wr_do(12'h340, 32'hDEAD_BEEF, 2'd1, "R3 scratch from S");
    wr_do(12'h340, 32'hCAFE_0001, 2'd0, "R3 scratch from U");
    rd_chk(12'h340, "R13 illegal write dropped");
    // R2: write to hart id flagged, value kept
    wr_do(12'hF14, 32'h0, 2'd3, "R2 id write");
    rd_chk(12'hF14, "R2 id value");

    // R12 R13: trap entry racing a write to epc
    t_pc = 32'h8000_0104; t_irq = 1; t_code = 31'd7; t_val = 32'h0;
    trap = 1;
    acc(12'h341, 32'h1111_1111, 1, 0, 2'd3, rd, il);
    s_epc = t_pc; s_cause = {t_irq, t_code}; s_tval = t_val;
    rd_chk(12'h341, "R13 trap wins over epc write");
    rd_chk(12'h342, "R12 interrupt cause");
    rd_chk(12'h343, "R12 tval");

    // R12 R13: exception trap with concurrent scratch write
    t_pc = 32'h0000_2220; t_irq = 0; t_code = 31'd2; t_val = 32'hBAD0_0004;
    trap = 1;
    acc(12'h340, 32'h7777_0000, 1, 0, 2'd3, rd, il);
    s_epc = t_pc; s_cause = {t_irq, t_code}; s_tval = t_val; s_scratch = 32'h7777_0000;
    read_all("R12 R13 exception trap with scratch write");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule